// File: doc/BRIEF.md
# IDE DMA Transfer Sequencer

This block carries one IDE DMA command from start to finish while an outside descriptor engine feeds it one memory chunk at a time. On a start command it latches the drive type, the direction and the addressing fields. It loads the number of bytes still owed and clears a running byte index. It then raises the DMA-active flag and sends a one-cycle kick to the descriptor engine.

For each chunk the engine offers, the sequencer decides what to do. If DMA is not armed, it hands the channel back untouched. If nothing is owed, it finishes the command. A zero-length chunk is closed on its own. A packet drive with no block address copies its buffered bytes directly. Otherwise the sequencer issues one storage request at the computed byte offset and advances its counters. It takes no new chunk until storage acknowledges that request. Finishing sets the drive status and raises the drive interrupt. A storage error or an unknown direction ends the command with an error.

Top module: `ide_dma_seq`

## Requirements
- R1: After reset, `status` is 0x00 and `drive_irq`, `dma_active` and `st_req` are low, with `chunk_ready` high.
- R2: A `start` pulse clears the byte index and `drive_irq`. In the following cycle it sets `dma_active` and gives a one-cycle `kick` pulse.
- R3: For a disk (`start_optical`=0), the bytes owed are loaded as `sector_count`×512. Each request's `st_offset` is `start_sector`×512 plus the byte index.
- R4: For a packet drive (`start_optical`=1), the bytes owed are loaded as `packet_size`. Each request's `st_offset` is `block_addr`×2048 plus the byte index.
- R5: A chunk accepted while `dma_active` is low yields only a `chunk_parked` pulse. It issues no request, no `chunk_done` and no completion.
- R6: Only one storage request is outstanding at a time. While `st_req` is high, `chunk_ready` is low and `st_offset`, `st_len` and `st_write` hold steady until `st_ack`.
- R7: Issuing a request subtracts the chunk length from the bytes owed and adds it to the byte index. `st_ack` then drops `st_req` and pulses `chunk_done` in the next cycle.
- R8: A zero-length chunk pulses only `chunk_done`. No request is made and `dma_active` stays set.
- R9: When a chunk arrives with zero or negative bytes owed, the command completes. `cmd_done` and `chunk_done` pulse, `status` becomes 0x50 (ready 0x40 plus seek 0x10), `drive_irq` rises and `dma_active` clears.
- R10: For a packet drive whose `block_addr` is all ones, a non-empty chunk pulses `copy_valid` with `copy_len` = min(bytes owed, chunk length). The command then completes as in R9.
- R11: An `st_ack` with `st_err` high pulses `err`, sets `status` to 0x41 (ready plus error bit 0), raises `drive_irq` and clears `dma_active`.
- R12: The direction is latched at start: code 0 reads (`st_write`=0) and code 1 writes (`st_write`=1). Codes 2 and 3 make the next transferring chunk pulse `err` with status 0x41 and issue no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new command |
| start_optical | input | 1 | 1 = packet drive, 0 = disk |
| start_dir | input | 2 | Direction code (0 read, 1 write) |
| sector_count | input | SECW | Disk sectors to move |
| packet_size | input | BYTEW | Packet transfer size in bytes |
| start_sector | input | LBAW | Disk starting sector |
| block_addr | input | LBAW | Packet block address, all ones = none |
| kick | output | 1 | Pulse telling the descriptor engine to run |
| chunk_valid | input | 1 | Descriptor engine offers a chunk |
| chunk_len | input | BYTEW | Chunk length in bytes |
| chunk_ready | output | 1 | Sequencer can take a chunk |
| chunk_done | output | 1 | Current chunk finished |
| chunk_parked | output | 1 | Chunk returned unused, DMA not armed |
| st_req | output | 1 | Storage request pending |
| st_write | output | 1 | Request is a write |
| st_offset | output | LBAW+12 | Storage byte offset |
| st_len | output | BYTEW | Request length in bytes |
| st_ack | input | 1 | Storage acknowledges the request |
| st_err | input | 1 | Storage reports an error with the ack |
| copy_valid | output | 1 | Direct buffer copy pulse |
| copy_len | output | BYTEW | Bytes copied from the buffer |
| cmd_done | output | 1 | Command finished successfully |
| err | output | 1 | Command ended in error |
| drive_irq | output | 1 | Drive interrupt level |
| dma_active | output | 1 | DMA armed for the current command |
| status | output | 8 | Drive status byte |

## Verification
On every cycle, the assertions check the start-to-kick handshake and parking while DMA is disarmed. They also check that only one storage request is outstanding and that the request fields stay stable. Finally, they check that completion and error each leave the status, interrupt and active flag consistent. The offset arithmetic for both drive types, the counter advance across chunks, the negative-remaining finish and the min rule of the direct copy can only be shown by the bench's scenarios. The same holds for the direction decode, since each depends on values computed from a whole command.

// File: rtl/ide_dma_seq_pkg.sv
// Shared constants and types for the IDE DMA transfer sequencer.
package ide_dma_seq_pkg;
    localparam logic [7:0] ST_READY = 8'h40;
    localparam logic [7:0] ST_SEEK  = 8'h10;
    localparam logic [7:0] ST_ERR   = 8'h01;

    typedef enum logic [1:0] {
        DIR_RD   = 2'd0,
        DIR_WR   = 2'd1,
        DIR_RSV2 = 2'd2,
        DIR_RSV3 = 2'd3
    } dir_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_WAIT = 1'b1
    } state_e;
endpackage

// File: rtl/ide_dma_seq_cnt.sv
// Byte bookkeeping for one command: a signed count of bytes still owed and
// a running byte index. Assumes load and adv are never high together.
module ide_dma_seq_cnt #(
    parameter int BYTEW = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [BYTEW-1:0] load_bytes,
    input  logic             adv,
    input  logic [BYTEW-1:0] adv_len,
    output logic             rem_pos,
    output logic [BYTEW-1:0] rem_bytes,
    output logic [BYTEW-1:0] idx
);
    logic signed [BYTEW:0] rem_q;

    // Load on start, step by the chunk length on each issued request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            idx   <= '0;
        end else if (load) begin
            rem_q <= $signed({1'b0, load_bytes});
            idx   <= '0;
        end else if (adv) begin
            rem_q <= rem_q - $signed({1'b0, adv_len});
            idx   <= idx + adv_len;
        end
    end

    // Positive test and magnitude view for the comparison logic.
    always_comb begin
        rem_pos   = (rem_q > 0);
        rem_bytes = rem_q[BYTEW-1:0];
    end
endmodule

// File: rtl/ide_dma_seq_off.sv
// Storage byte offset: base block scaled by the drive's block size, plus the
// running index. Disk blocks are 512 bytes and packet blocks 2048 bytes.
module ide_dma_seq_off #(
    parameter int LBAW  = 16,
    parameter int BYTEW = 20,
    parameter int OFFW  = 28
) (
    input  logic             optical,
    input  logic [LBAW-1:0]  sector,
    input  logic [LBAW-1:0]  blk,
    input  logic [BYTEW-1:0] idx,
    output logic [OFFW-1:0]  offset
);
    localparam int DISK_SH = 9;
    localparam int PKT_SH  = 11;

    logic [OFFW-1:0] base_disk, base_pkt;

    // Scale each base by its block size, then add the index.
    always_comb begin
        base_disk = OFFW'(sector) << DISK_SH;
        base_pkt  = OFFW'(blk) << PKT_SH;
        offset    = (optical ? base_pkt : base_disk) + OFFW'(idx);
    end
endmodule

// File: rtl/ide_dma_seq.sv
// IDE DMA transfer sequencer. A descriptor engine offers chunks one at a
// time, and each chunk is parked, closed, copied, or turned into a single
// storage request. Assumes storage answers every request with st_ack.
module ide_dma_seq
    import ide_dma_seq_pkg::*;
#(
    parameter int SECW  = 8,
    parameter int BYTEW = 20,
    parameter int LBAW  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 start_optical,
    input  logic [1:0]           start_dir,
    input  logic [SECW-1:0]      sector_count,
    input  logic [BYTEW-1:0]     packet_size,
    input  logic [LBAW-1:0]      start_sector,
    input  logic [LBAW-1:0]      block_addr,
    output logic                 kick,
    input  logic                 chunk_valid,
    input  logic [BYTEW-1:0]     chunk_len,
    output logic                 chunk_ready,
    output logic                 chunk_done,
    output logic                 chunk_parked,
    output logic                 st_req,
    output logic                 st_write,
    output logic [LBAW+11:0]     st_offset,
    output logic [BYTEW-1:0]     st_len,
    input  logic                 st_ack,
    input  logic                 st_err,
    output logic                 copy_valid,
    output logic [BYTEW-1:0]     copy_len,
    output logic                 cmd_done,
    output logic                 err,
    output logic                 drive_irq,
    output logic                 dma_active,
    output logic [7:0]           status
);
    localparam int OFFW = LBAW + 12;

    state_e           state;
    logic             opt_q;
    dir_e             dir_q;
    logic [LBAW-1:0]  sector_q, blk_q;
    logic             accept, no_addr, dir_ok, len_zero, issue;
    logic             rem_pos;
    logic [BYTEW-1:0] rem_bytes, idx, load_bytes;
    logic [OFFW-1:0]  off_now;

    // Decode the offered chunk against the latched command.
    always_comb begin
        chunk_ready = (state == S_IDLE);
        accept      = chunk_valid && chunk_ready && !start;
        no_addr     = opt_q && (&blk_q);
        dir_ok      = (dir_q == DIR_RD) || (dir_q == DIR_WR);
        len_zero    = (chunk_len == '0);
        issue       = accept && dma_active && rem_pos && !len_zero && !no_addr && dir_ok;
        load_bytes  = start_optical ? packet_size : BYTEW'({sector_count, 9'b0});
    end

    ide_dma_seq_cnt #(.BYTEW(BYTEW)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .load(start), .load_bytes(load_bytes),
        .adv(issue), .adv_len(chunk_len),
        .rem_pos(rem_pos), .rem_bytes(rem_bytes), .idx(idx)
    );

    ide_dma_seq_off #(.LBAW(LBAW), .BYTEW(BYTEW), .OFFW(OFFW)) u_off (
        .optical(opt_q), .sector(sector_q), .blk(blk_q),
        .idx(idx), .offset(off_now)
    );

    // Command sequencing, request handshake and status reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;  opt_q <= 1'b0;  dir_q <= DIR_RD;
            sector_q <= '0;   blk_q <= '0;
            kick <= 1'b0;     chunk_done <= 1'b0;  chunk_parked <= 1'b0;
            st_req <= 1'b0;   st_write <= 1'b0;    st_offset <= '0;  st_len <= '0;
            copy_valid <= 1'b0;  copy_len <= '0;
            cmd_done <= 1'b0; err <= 1'b0;  drive_irq <= 1'b0;
            dma_active <= 1'b0;  status <= 8'h00;
        end else begin
            kick <= 1'b0;  chunk_done <= 1'b0;  chunk_parked <= 1'b0;
            copy_valid <= 1'b0;  cmd_done <= 1'b0;  err <= 1'b0;
            if (start) begin
                opt_q <= start_optical;  dir_q <= dir_e'(start_dir);
                sector_q <= start_sector;  blk_q <= block_addr;
                state <= S_IDLE;  st_req <= 1'b0;
                dma_active <= 1'b1;  kick <= 1'b1;
                drive_irq <= 1'b0;  status <= 8'h00;
            end else if (state == S_WAIT) begin
                if (st_ack) begin
                    st_req <= 1'b0;  state <= S_IDLE;  chunk_done <= 1'b1;
                    if (st_err) begin
                        err <= 1'b1;  status <= ST_READY | ST_ERR;
                        drive_irq <= 1'b1;  dma_active <= 1'b0;
                    end
                end
            end else if (accept) begin
                if (!dma_active) begin
                    chunk_parked <= 1'b1;
                end else if (!rem_pos || (no_addr && !len_zero)) begin
                    if (rem_pos) begin
                        copy_valid <= 1'b1;
                        copy_len   <= (rem_bytes < chunk_len) ? rem_bytes : chunk_len;
                    end
                    cmd_done <= 1'b1;  chunk_done <= 1'b1;
                    status <= ST_READY | ST_SEEK;
                    drive_irq <= 1'b1;  dma_active <= 1'b0;
                end else if (len_zero) begin
                    chunk_done <= 1'b1;
                end else if (!dir_ok) begin
                    err <= 1'b1;  chunk_done <= 1'b1;
                    status <= ST_READY | ST_ERR;
                    drive_irq <= 1'b1;  dma_active <= 1'b0;
                end else begin
                    st_req <= 1'b1;  st_write <= (dir_q == DIR_WR);
                    st_offset <= off_now;  st_len <= chunk_len;
                    state <= S_WAIT;
                end
            end
        end
    end
endmodule

// File: rtl/ide_dma_seq_chk.sv
// Cycle-level properties of the sequencer, attached by bind.
module ide_dma_seq_chk #(
    parameter int BYTEW = 20,
    parameter int OFFW  = 28
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             kick,
    input logic             chunk_valid,
    input logic             chunk_ready,
    input logic             chunk_parked,
    input logic             st_req,
    input logic             st_write,
    input logic [OFFW-1:0]  st_offset,
    input logic [BYTEW-1:0] st_len,
    input logic             st_ack,
    input logic             cmd_done,
    input logic             err,
    input logic             drive_irq,
    input logic             dma_active,
    input logic [7:0]       status
);
    p_kick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> kick && dma_active && !drive_irq);

    p_park_r5: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_valid && chunk_ready && !dma_active && !start
        |=> chunk_parked && !st_req && !cmd_done);

    p_one_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_req |-> !chunk_ready);

    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_req && !st_ack && !start
        |=> st_req && $stable(st_offset) && $stable(st_len) && $stable(st_write));

    p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> !dma_active && drive_irq && status == 8'h50);

    p_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !dma_active && drive_irq && status == 8'h41 && !cmd_done);
endmodule

bind ide_dma_seq ide_dma_seq_chk #(.BYTEW(BYTEW), .OFFW(OFFW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .kick(kick),
    .chunk_valid(chunk_valid), .chunk_ready(chunk_ready),
    .chunk_parked(chunk_parked), .st_req(st_req), .st_write(st_write),
    .st_offset(st_offset), .st_len(st_len), .st_ack(st_ack),
    .cmd_done(cmd_done), .err(err), .drive_irq(drive_irq),
    .dma_active(dma_active), .status(status)
);

// File: tb/ide_dma_seq_tb.sv
module ide_dma_seq_tb;
    localparam int SECW = 8, BYTEW = 20, LBAW = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 0, start_optical = 0;
    logic [1:0] start_dir = 0;
    logic [SECW-1:0] sector_count = 0;
    logic [BYTEW-1:0] packet_size = 0, chunk_len = 0;
    logic [LBAW-1:0] start_sector = 0, block_addr = 0;
    logic chunk_valid = 0, st_ack = 0, st_err = 0;
    logic kick, chunk_ready, chunk_done, chunk_parked, st_req, st_write;
    logic [LBAW+11:0] st_offset;
    logic [BYTEW-1:0] st_len, copy_len;
    logic copy_valid, cmd_done, err, drive_irq, dma_active;
    logic [7:0] status;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    ide_dma_seq #(.SECW(SECW), .BYTEW(BYTEW), .LBAW(LBAW)) u_dut (.*);

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic do_start(input bit opt, input logic [1:0] dir, input int sec,
                            input int pkt, input int ssec, input int blk);
        @(negedge clk);
        start = 1; start_optical = opt; start_dir = dir;
        sector_count = SECW'(sec); packet_size = BYTEW'(pkt);
        start_sector = LBAW'(ssec); block_addr = LBAW'(blk);
        @(negedge clk);
        start = 0;
        chk("R2 kick", kick, 1);
        chk("R2 dma_active", dma_active, 1);
        chk("R2 irq cleared", drive_irq, 0);
    endtask

    task automatic send_chunk(input int len);
        @(negedge clk);
        chunk_valid = 1; chunk_len = BYTEW'(len);
        @(negedge clk);
        chunk_valid = 0;
    endtask

    task automatic do_ack(input bit e);
        st_ack = 1; st_err = e;
        @(negedge clk);
        st_ack = 0; st_err = 0;
    endtask

    task automatic t_reset();
        chk("R1 status", status, 0);
        chk("R1 irq", drive_irq, 0);
        chk("R1 dma_active", dma_active, 0);
        chk("R1 st_req", st_req, 0);
        chk("R1 chunk_ready", chunk_ready, 1);
    endtask

    task automatic t_disk_write();
        do_start(0, 2'd1, 2, 0, 5, 0);
        send_chunk(512);
        chk("R3 req", st_req, 1);
        chk("R12 write", st_write, 1);
        chk("R3 offset", st_offset, 5 * 512);
        chk("R7 len", st_len, 512);
        chk("R6 not ready", chunk_ready, 0);
        @(negedge clk);
        chk("R6 held", st_req, 1);
        chk("R6 offset stable", st_offset, 5 * 512);
        do_ack(0);
        chk("R7 chunk_done", chunk_done, 1);
        chk("R7 req drop", st_req, 0);
        send_chunk(512);
        chk("R7 offset advanced", st_offset, 5 * 512 + 512);
        do_ack(0);
        send_chunk(256);
        chk("R9 cmd_done", cmd_done, 1);
        chk("R9 chunk_done", chunk_done, 1);
        chk("R9 status", status, 8'h50);
        chk("R9 irq", drive_irq, 1);
        chk("R9 dma_active", dma_active, 0);
        chk("R9 no req", st_req, 0);
    endtask

    task automatic t_park();
        send_chunk(100);
        chk("R5 parked", chunk_parked, 1);
        chk("R5 no req", st_req, 0);
        chk("R5 no chunk_done", chunk_done, 0);
        chk("R5 no cmd_done", cmd_done, 0);
    endtask

    task automatic t_zero_and_overshoot();
        do_start(0, 2'd0, 1, 0, 0, 0);
        send_chunk(0);
        chk("R8 chunk_done", chunk_done, 1);
        chk("R8 no req", st_req, 0);
        chk("R8 still active", dma_active, 1);
        send_chunk(1024);
        chk("R12 read", st_write, 0);
        chk("R3 offset zero", st_offset, 0);
        do_ack(0);
        send_chunk(512);
        chk("R9 negative remaining completes", cmd_done, 1);
        chk("R9 no req after overshoot", st_req, 0);
    endtask

    task automatic t_optical();
        do_start(1, 2'd0, 0, 4096, 0, 3);
        send_chunk(2048);
        chk("R4 offset", st_offset, 3 * 2048);
        do_ack(0);
        send_chunk(2048);
        chk("R4 offset advanced", st_offset, 3 * 2048 + 2048);
        do_ack(0);
        send_chunk(16);
        chk("R4 completes after packet size", cmd_done, 1);
    endtask

    task automatic t_no_addr();
        do_start(1, 2'd0, 0, 100, 0, 16'hFFFF);
        send_chunk(512);
        chk("R10 copy_valid", copy_valid, 1);
        chk("R10 copy_len", copy_len, 100);
        chk("R10 cmd_done", cmd_done, 1);
        chk("R10 no req", st_req, 0);
        chk("R10 dma_active", dma_active, 0);
        do_start(1, 2'd0, 0, 600, 0, 16'hFFFF);
        send_chunk(300);
        chk("R10 copy_len chunk bound", copy_len, 300);
    endtask

    task automatic t_store_err();
        do_start(0, 2'd0, 4, 0, 1, 0);
        send_chunk(512);
        do_ack(1);
        chk("R11 err", err, 1);
        chk("R11 status", status, 8'h41);
        chk("R11 irq", drive_irq, 1);
        chk("R11 dma_active", dma_active, 0);
        chk("R11 no cmd_done", cmd_done, 0);
    endtask

    task automatic t_bad_dir();
        do_start(0, 2'd2, 4, 0, 1, 0);
        send_chunk(512);
        chk("R12 err", err, 1);
        chk("R12 no req", st_req, 0);
        chk("R12 status", status, 8'h41);
        chk("R12 dma_active", dma_active, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_disk_write();
        t_park();
        t_zero_and_overshoot();
        t_optical();
        t_no_addr();
        t_store_err();
        t_bad_dir();
        repeat (2) @(negedge clk);
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end
endmodule